// File: doc/BRIEF.md
# Regulator Fault Protection Supervisor

This block times, latches and acts on the fault flags of a two-phase voltage regulator. Analog comparators outside the block produce one digital flag per fault class: overcurrent, severe overcurrent, absolute overvoltage, relative overvoltage, undervoltage and phase-current mismatch. A further flag reports that the output has discharged below the release level. The block requires each flag to persist for the time that belongs to its class before that fault latches. It then drives the protective action for the class: it requests three-state on both PWM outputs, holds the low-side switch on, or only drops power-good.

Each persistence time is given in microseconds and turned into a whole number of clock cycles at elaboration, using the clock-frequency parameter. The absolute overvoltage class acts at once. It first holds the low-side switch on until the output has discharged, then three-states the PWM outputs. Only the supply reset clears it. The enable input clears every other class. A three-bit cause register keeps the first fault that latched. A select bit tells the external comparator to use the halved overcurrent setpoint while the regulator runs on one phase.

Top module: `vr_fault_supervisor`

## Requirements
- R1: After a supply reset (`rst_n` sampled low) with `en_i` high, `pgood_o`=1, `pwm_hiz_o`=0, `low_side_on_o`=0, `cause_o`=0 and `oc_half_sel_o`=0.
- R2: When `oc_flag_i` is sampled high on N_OC consecutive edges (120 us of clock), the overcurrent fault latches on the N_OC-th edge: `pwm_hiz_o`=1 and `pgood_o`=0 from that edge on. A low sample before then restarts the count from zero.
- R3: `oc_severe_flag_i` follows the same rule with a 2 us window, and its action is the same as in R2.
- R4: `ov_rel_flag_i` held for 1 ms latches a fault that drives `pgood_o`=0 and leaves `pwm_hiz_o`=0.
- R5: `uv_flag_i` held for 1 ms latches a fault that drives `pwm_hiz_o`=1 and `pgood_o`=0.
- R6: `unbal_flag_i` is timed (1 ms, action as R5) only while `single_phase_i`=0. While `single_phase_i`=1 its count is held at zero and it never latches.
- R7: A single sampled high of `ov_abs_flag_i` latches at that edge: `low_side_on_o`=1, `pwm_hiz_o`=0, `pgood_o`=0. While that discharge lasts, the first edge that samples `below_release_i` high moves to `low_side_on_o`=0, `pwm_hiz_o`=1.
- R8: The absolute overvoltage state and its outputs persist through `en_i` low. Only `rst_n` low clears them.
- R9: An edge that samples `en_i` low clears all other latched faults and all persistence counts. `pgood_o` is 0 while `en_i` is 0 and returns to 1 when `en_i` is high with no fault latched.
- R10: `oc_half_sel_o` equals `single_phase_i` as sampled on the previous edge (1 = halved overcurrent setpoint).
- R11: `cause_o` codes: 0 none, 1 overcurrent, 2 severe overcurrent, 3 absolute overvoltage, 4 relative overvoltage, 5 undervoltage, 6 mismatch. It records the first latch and ignores later ones. Among latches on the same edge the order is 3, 2, 1, 5, 6, 4. A clear by `en_i` sets it to 3 if the absolute overvoltage state is active and to 0 otherwise.
- R12: Each window is ceil(CLK_HZ x us / 1e6) cycles, and at least 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low supply reset |
| en_i | input | 1 | Regulator enable; low clears the faults that it may clear |
| single_phase_i | input | 1 | 1 = single-phase mode |
| oc_flag_i | input | 1 | Overcurrent comparator flag |
| oc_severe_flag_i | input | 1 | Severe overcurrent flag |
| ov_abs_flag_i | input | 1 | Absolute overvoltage flag |
| ov_rel_flag_i | input | 1 | Overvoltage-above-target flag |
| uv_flag_i | input | 1 | Undervoltage flag |
| unbal_flag_i | input | 1 | Phase-current mismatch flag |
| below_release_i | input | 1 | Output has discharged below the release level |
| pwm_hiz_o | output | 1 | Request three-state on both PWM outputs |
| low_side_on_o | output | 1 | Request the low-side switch held on |
| pgood_o | output | 1 | Power-good |
| oc_half_sel_o | output | 1 | Select the halved overcurrent setpoint |
| cause_o | output | 3 | First latched fault cause |

## Verification
A persistence counter that is off by one cycle, or that fails to restart, moves the latch edge. At the ports, `pwm_hiz_o` or `pgood_o` then changes one edge early or late, or a glitch that is one cycle too short latches. The bench therefore checks one edge before each window ends and again at the window's last edge. A wrong discharge state shows at the edge that samples the release flag or the enable clear, as the wrong one of `low_side_on_o` or `pwm_hiz_o`. A cause register that is overwritten shows the first time a second fault latches. A reference model compared on every cycle under random flag bursts finds these errors within a cycle of the edge that exposes them.

// File: rtl/vrfs_pkg.sv
// Shared types and helpers for the regulator fault supervisor.
// Assumes window lengths fit in 32 bits once converted to cycles.
package vrfs_pkg;

    // Fault cause codes, as seen on the cause output.
    typedef enum logic [2:0] {
        CAUSE_NONE      = 3'd0,
        CAUSE_OC        = 3'd1,
        CAUSE_OC_SEVERE = 3'd2,
        CAUSE_OV_ABS    = 3'd3,
        CAUSE_OV_REL    = 3'd4,
        CAUSE_UV        = 3'd5,
        CAUSE_UNBAL     = 3'd6
    } cause_e;

    // Discharge sequence of the absolute overvoltage class.
    typedef enum logic [1:0] {
        DIS_IDLE  = 2'd0,
        DIS_DRAIN = 2'd1,
        DIS_OFF   = 2'd2
    } dis_state_e;

    // Index of each timed fault class in the timer vector.
    localparam int NUM_TIMED = 5;
    localparam int TI_OC     = 0;
    localparam int TI_OCS    = 1;
    localparam int TI_OVR    = 2;
    localparam int TI_UV     = 3;
    localparam int TI_UNB    = 4;

    // Convert microseconds to clock cycles, rounded up, never below one.
    function automatic int unsigned us_to_cycles(input longint unsigned hz,
                                                 input longint unsigned us);
        longint unsigned c;
        c = (hz * us + 64'd999_999) / 64'd1_000_000;
        if (c == 64'd0) c = 64'd1;
        return c[31:0];
    endfunction

endpackage

// File: rtl/persist_timer.sv
// Persistence timer: raises hit_o on the CYCLES-th consecutive sampled high
// of flag_i. A low sample or an active clear restarts the count.
// Assumes CYCLES >= 1. After the hit the count saturates, so hit_o stays high.
module persist_timer #(
    parameter int unsigned CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic flag_i,
    output logic hit_o
);
    localparam int unsigned CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Count consecutive high samples; saturate at the last step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || !flag_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // Hit when the current sample completes the window.
    assign hit_o = flag_i && !clr_i && (cnt_q == LAST);

endmodule

// File: rtl/ovp_discharge_fsm.sv
// Absolute overvoltage sequence: a trip moves to the drain state, where the
// low-side switch is held on. A sampled release flag then moves to the off
// state, where the PWM outputs are three-stated. Only rst_n leaves either state.
module ovp_discharge_fsm
    import vrfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    input  logic below_i,
    output logic active_o,
    output logic drain_o,
    output logic off_o
);
    dis_state_e state_q;
    dis_state_e state_d;

    // Next-state choice of the discharge sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            DIS_IDLE:  if (trip_i)  state_d = DIS_DRAIN;
            DIS_DRAIN: if (below_i) state_d = DIS_OFF;
            default:                state_d = state_q;
        endcase
    end

    // State register; the supply reset is the only exit.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DIS_IDLE;
        else        state_q <= state_d;
    end

    assign active_o = (state_q != DIS_IDLE);
    assign drain_o  = (state_q == DIS_DRAIN);
    assign off_o    = (state_q == DIS_OFF);

endmodule

// File: rtl/fault_cause_reg.sv
// First-fault cause register. It stores the highest-priority class that
// latches while empty and holds it until a clear. A clear by the enable keeps
// the absolute overvoltage code when that class is active.
module fault_cause_reg
    import vrfs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic                 abs_hit_i,
    input  logic                 abs_active_i,
    input  logic [NUM_TIMED-1:0] timed_hit_i,
    output cause_e               cause_o
);
    cause_e pick;
    cause_e cause_q;

    // Priority pick among the classes that latch on this edge.
    always_comb begin
        if (abs_hit_i)                  pick = CAUSE_OV_ABS;
        else if (timed_hit_i[TI_OCS])   pick = CAUSE_OC_SEVERE;
        else if (timed_hit_i[TI_OC])    pick = CAUSE_OC;
        else if (timed_hit_i[TI_UV])    pick = CAUSE_UV;
        else if (timed_hit_i[TI_UNB])   pick = CAUSE_UNBAL;
        else if (timed_hit_i[TI_OVR])   pick = CAUSE_OV_REL;
        else                            pick = CAUSE_NONE;
    end

    // Record the first cause; clear on reset or on enable low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= CAUSE_NONE;
        end else if (!en_i) begin
            cause_q <= (abs_active_i || abs_hit_i) ? CAUSE_OV_ABS : CAUSE_NONE;
        end else if (cause_q == CAUSE_NONE) begin
            cause_q <= pick;
        end
    end

    assign cause_o = cause_q;

endmodule

// File: rtl/vr_fault_supervisor.sv
// Fault timing and latching supervisor for a two-phase regulator.
// It times the comparator flags, latches faults, drives the protective
// requests, power-good and the cause code, and selects the halved overcurrent
// setpoint in single-phase mode.
// Assumes the flags are synchronous to clk, and rst_n is the supply reset.
module vr_fault_supervisor
    import vrfs_pkg::*;
#(
    parameter int unsigned CLK_HZ       = 10_000_000,
    parameter int unsigned OC_US        = 120,
    parameter int unsigned OC_SEVERE_US = 2,
    parameter int unsigned OV_REL_US    = 1000,
    parameter int unsigned UV_US        = 1000,
    parameter int unsigned UNBAL_US     = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       single_phase_i,
    input  logic       oc_flag_i,
    input  logic       oc_severe_flag_i,
    input  logic       ov_abs_flag_i,
    input  logic       ov_rel_flag_i,
    input  logic       uv_flag_i,
    input  logic       unbal_flag_i,
    input  logic       below_release_i,
    output logic       pwm_hiz_o,
    output logic       low_side_on_o,
    output logic       pgood_o,
    output logic       oc_half_sel_o,
    output logic [2:0] cause_o
);
    localparam int unsigned CYC_OC  = us_to_cycles(64'(CLK_HZ), 64'(OC_US));
    localparam int unsigned CYC_OCS = us_to_cycles(64'(CLK_HZ), 64'(OC_SEVERE_US));
    localparam int unsigned CYC_OVR = us_to_cycles(64'(CLK_HZ), 64'(OV_REL_US));
    localparam int unsigned CYC_UV  = us_to_cycles(64'(CLK_HZ), 64'(UV_US));
    localparam int unsigned CYC_UNB = us_to_cycles(64'(CLK_HZ), 64'(UNBAL_US));
    localparam int unsigned TMR_CYC [NUM_TIMED] =
        '{CYC_OC, CYC_OCS, CYC_OVR, CYC_UV, CYC_UNB};

    logic [NUM_TIMED-1:0] timed_flag;
    logic [NUM_TIMED-1:0] timed_hit;
    logic [NUM_TIMED-1:0] lat_q;
    logic                 timer_clr;
    logic                 abs_active;
    logic                 abs_drain;
    logic                 abs_off;
    logic                 shut_req;
    logic                 half_q;
    cause_e               cause_q;

    assign timer_clr = !en_i;

    // Gather the timed flags; the mismatch flag counts only in two-phase mode.
    always_comb begin
        timed_flag          = '0;
        timed_flag[TI_OC]   = oc_flag_i;
        timed_flag[TI_OCS]  = oc_severe_flag_i;
        timed_flag[TI_OVR]  = ov_rel_flag_i;
        timed_flag[TI_UV]   = uv_flag_i;
        timed_flag[TI_UNB]  = unbal_flag_i && !single_phase_i;
    end

    for (genvar g = 0; g < NUM_TIMED; g++) begin : g_tmr
        persist_timer #(
            .CYCLES (TMR_CYC[g])
        ) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (timer_clr),
            .flag_i (timed_flag[g]),
            .hit_o  (timed_hit[g])
        );
    end

    // Latch the timed faults; enable low or supply reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) lat_q <= '0;
        else                 lat_q <= lat_q | timed_hit;
    end

    ovp_discharge_fsm u_ovp (
        .clk      (clk),
        .rst_n    (rst_n),
        .trip_i   (ov_abs_flag_i),
        .below_i  (below_release_i),
        .active_o (abs_active),
        .drain_o  (abs_drain),
        .off_o    (abs_off)
    );

    fault_cause_reg u_cause (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en_i),
        .abs_hit_i    (ov_abs_flag_i),
        .abs_active_i (abs_active),
        .timed_hit_i  (timed_hit),
        .cause_o      (cause_q)
    );

    // Register the phase mode to select the halved overcurrent setpoint.
    always_ff @(posedge clk) begin
        if (!rst_n) half_q <= 1'b0;
        else        half_q <= single_phase_i;
    end

    assign shut_req      = lat_q[TI_OC] | lat_q[TI_OCS] | lat_q[TI_UV] | lat_q[TI_UNB];
    assign pwm_hiz_o     = abs_active ? abs_off : shut_req;
    assign low_side_on_o = abs_drain;
    assign pgood_o       = en_i && (lat_q == '0) && !abs_active;
    assign oc_half_sel_o = half_q;
    assign cause_o       = cause_q;

endmodule

// File: rtl/vr_fault_supervisor_chk.sv
// Port-level properties of the fault supervisor, bound to every instance.
module vr_fault_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_i,
    input logic       single_phase_i,
    input logic       ov_abs_flag_i,
    input logic       pwm_hiz_o,
    input logic       low_side_on_o,
    input logic       pgood_o,
    input logic       oc_half_sel_o,
    input logic [2:0] cause_o
);
    assert_drain_excl_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(low_side_on_o && pwm_hiz_o));

    assert_abs_acts_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ov_abs_flag_i |=> (low_side_on_o || pwm_hiz_o) && !pgood_o);

    assert_hiz_drops_pgood_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_hiz_o |-> !pgood_o);

    assert_half_follows_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (oc_half_sel_o == $past(single_phase_i)));

    assert_cause_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && cause_o != 3'd0) |=> (cause_o == $past(cause_o)));

    assert_abs_survives_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_o == 3'd3 && !en_i) |=> (cause_o == 3'd3));

endmodule

bind vr_fault_supervisor vr_fault_supervisor_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .en_i           (en_i),
    .single_phase_i (single_phase_i),
    .ov_abs_flag_i  (ov_abs_flag_i),
    .pwm_hiz_o      (pwm_hiz_o),
    .low_side_on_o  (low_side_on_o),
    .pgood_o        (pgood_o),
    .oc_half_sel_o  (oc_half_sel_o),
    .cause_o        (cause_o)
);

// File: tb/vr_fault_supervisor_tb_top.sv
// Bench: directed corner cases, then random flag bursts. The outputs are
// compared on every cycle with a reference model written from the requirements.
module vr_fault_supervisor_tb_top;
    localparam int CLK_PERIOD = 10;
    // R12: 1_999_999 Hz makes each window round up: 240, 4 and 2000 cycles.
    localparam int unsigned BENCH_HZ = 1_999_999;
    localparam int N_OC  = 240;
    localparam int N_OCS = 4;
    localparam int N_MS  = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1, sp = 1'b0, oc = 1'b0, ocs = 1'b0, ova = 1'b0;
    logic ovr = 1'b0, uv = 1'b0, unb = 1'b0, blw = 1'b0;
    logic pwm_hiz, low_side_on, pgood, half_sel;
    logic [2:0] cause;

    int checks = 0;
    int fails = 0;
    bit armed = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vr_fault_supervisor #(.CLK_HZ(BENCH_HZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .single_phase_i(sp),
        .oc_flag_i(oc), .oc_severe_flag_i(ocs), .ov_abs_flag_i(ova),
        .ov_rel_flag_i(ovr), .uv_flag_i(uv), .unbal_flag_i(unb),
        .below_release_i(blw), .pwm_hiz_o(pwm_hiz), .low_side_on_o(low_side_on),
        .pgood_o(pgood), .oc_half_sel_o(half_sel), .cause_o(cause)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int  mcnt [5] = '{0, 0, 0, 0, 0};
    bit  [4:0] mlat = '0;
    int  mst = 0;      // 0 idle, 1 drain, 2 off
    int  mcause = 0;
    bit  mhalf = 1'b0;

    function automatic int win(input int i);
        case (i)
            0: return N_OC;
            1: return N_OCS;
            default: return N_MS;
        endcase
    endfunction

    function automatic int pick(input bit a, input bit [4:0] h);
        if (a)    return 3;
        if (h[1]) return 2;
        if (h[0]) return 1;
        if (h[3]) return 5;
        if (h[4]) return 6;
        if (h[2]) return 4;
        return 0;
    endfunction

    always @(posedge clk) begin
        bit [4:0] f;
        bit [4:0] h;
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) mcnt[i] = 0;
            mlat = '0; mst = 0; mcause = 0; mhalf = 1'b0;
        end else begin
            f = {unb && !sp, uv, ovr, ocs, oc};
            for (int i = 0; i < 5; i++) begin
                h[i] = en && f[i] && (mcnt[i] >= win(i) - 1);
                if (!en || !f[i]) mcnt[i] = 0;
                else if (mcnt[i] < win(i) - 1) mcnt[i]++;
            end
            if (!en) mcause = (mst != 0 || ova) ? 3 : 0;
            else if (mcause == 0) mcause = pick(ova, h);
            if (!en) mlat = '0; else mlat = mlat | h;
            if (mst == 0 && ova) mst = 1;
            else if (mst == 1 && blw) mst = 2;
            mhalf = sp;
        end
    end

    // Compare every cycle, before the drive point of the cycle.
    always @(negedge clk) begin
        #2;
        if (armed) begin
            chk("R2", "model pwm_hiz", int'(pwm_hiz),
                (mst != 0) ? int'(mst == 2) : int'(mlat[0] | mlat[1] | mlat[3] | mlat[4]));
            chk("R7", "model low_side_on", int'(low_side_on), int'(mst == 1));
            chk("R9", "model pgood", int'(pgood), int'(en && mlat == 0 && mst == 0));
            chk("R11", "model cause", int'(cause), mcause);
            chk("R10", "model half_sel", int'(half_sel), int'(mhalf));
        end
    end

    // Wait k edges; return at the check-and-drive point of the cycle.
    task automatic run(input int k);
        repeat (k) @(negedge clk);
        #3;
    endtask

    task automatic toggle_en();
        en = 1'b0; run(1); en = 1'b1; run(1);
    endtask

    task automatic all_low();
        oc = 0; ocs = 0; ova = 0; ovr = 0; uv = 0; unb = 0; blw = 0;
    endtask

    initial begin
        int hold [9];
        @(negedge clk); #3;
        run(3);
        rst_n = 1'b1; armed = 1'b1; run(1);
        // R1: state after reset
        chk("R1", "pgood", pgood, 1); chk("R1", "hiz", pwm_hiz, 0);
        chk("R1", "low_side", low_side_on, 0); chk("R1", "cause", cause, 0);
        chk("R1", "half", half_sel, 0);

        // R2: window of 240 edges, restart on a low sample
        oc = 1; run(N_OC - 1); chk("R2", "hiz one edge early", pwm_hiz, 0);
        oc = 0; run(1); oc = 1; run(N_OC - 1); chk("R2", "hiz after restart", pwm_hiz, 0);
        run(1); chk("R2", "hiz at window", pwm_hiz, 1); chk("R2", "pgood", pgood, 0);
        chk("R11", "cause oc", cause, 1);
        oc = 0;
        // R9: enable clear
        en = 0; run(1); chk("R9", "pgood en low", pgood, 0); chk("R9", "hiz cleared", pwm_hiz, 0);
        chk("R9", "cause cleared", cause, 0);
        en = 1; run(1); chk("R9", "pgood back", pgood, 1);

        // R3 and R10: severe window in single-phase mode
        sp = 1; ocs = 1; run(N_OCS - 1); chk("R3", "hiz early", pwm_hiz, 0);
        run(1); chk("R3", "hiz", pwm_hiz, 1); chk("R11", "cause severe", cause, 2);
        chk("R10", "half select", half_sel, 1);
        ocs = 0; toggle_en();

        // R6: mismatch ignored in single-phase, timed in two-phase
        unb = 1; run(N_MS + 100); chk("R6", "pgood single-phase", pgood, 1);
        sp = 0; run(N_MS - 1); chk("R6", "pgood early", pgood, 1);
        chk("R10", "half cleared", half_sel, 0);
        run(1); chk("R6", "hiz", pwm_hiz, 1); chk("R11", "cause mismatch", cause, 6);
        unb = 0; toggle_en();

        // R4: relative overvoltage keeps regulating
        ovr = 1; run(N_MS); chk("R4", "pgood", pgood, 0); chk("R4", "hiz", pwm_hiz, 0);
        chk("R11", "cause rel ov", cause, 4);
        ovr = 0; toggle_en();

        // R5 and R11: undervoltage first, a later overcurrent does not overwrite
        uv = 1; run(N_MS); chk("R5", "hiz", pwm_hiz, 1); chk("R5", "pgood", pgood, 0);
        chk("R11", "cause uv", cause, 5);
        oc = 1; run(N_OC); chk("R11", "cause kept", cause, 5);
        uv = 0; oc = 0; toggle_en();

        // R11: same-edge priority, mismatch over relative overvoltage
        ovr = 1; unb = 1; run(N_MS); chk("R11", "same-edge priority", cause, 6);
        ovr = 0; unb = 0; toggle_en();

        // R7 and R8: absolute overvoltage sequence
        ova = 1; run(1); chk("R7", "low_side", low_side_on, 1); chk("R7", "hiz", pwm_hiz, 0);
        chk("R7", "pgood", pgood, 0); chk("R11", "cause abs", cause, 3);
        ova = 0; run(5); chk("R7", "still draining", low_side_on, 1);
        blw = 1; run(1); chk("R7", "low_side off", low_side_on, 0); chk("R7", "hiz on", pwm_hiz, 1);
        blw = 0; toggle_en();
        chk("R8", "hiz kept", pwm_hiz, 1); chk("R8", "cause kept", cause, 3);
        chk("R8", "pgood low", pgood, 0);
        rst_n = 0; run(1); rst_n = 1; run(1);
        chk("R8", "hiz after reset", pwm_hiz, 0); chk("R8", "pgood after reset", pgood, 1);
        chk("R8", "cause after reset", cause, 0);

        // R11: absolute overvoltage wins over a severe overcurrent on the same edge
        ocs = 1; run(N_OCS - 1); ova = 1; run(1); chk("R11", "abs priority", cause, 3);
        all_low(); rst_n = 0; run(1); rst_n = 1; run(1);

        // Random bursts with a fixed seed
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 9; i++) hold[i] = 0;
        for (int cyc = 0; cyc < 60000; cyc++) begin
            for (int i = 0; i < 6; i++) begin
                if (hold[i] == 0) begin
                    bit v;
                    v = ($urandom_range(0, 3) == 0);
                    case (i)
                        0: begin oc  = v; hold[i] = $urandom_range(1, 300);  end
                        1: begin ocs = v; hold[i] = $urandom_range(1, 6);    end
                        2: begin ovr = v; hold[i] = $urandom_range(1, 2600); end
                        3: begin uv  = v; hold[i] = $urandom_range(1, 2600); end
                        4: begin unb = v; hold[i] = $urandom_range(1, 2600); end
                        default: begin sp = v; hold[i] = $urandom_range(1, 3000); end
                    endcase
                end else hold[i]--;
            end
            ova = ($urandom_range(0, 4999) == 0);
            blw = ($urandom_range(0, 19) == 0);
            if (hold[6] > 0) begin hold[6]--; if (hold[6] == 0) en = 1; end
            else if ($urandom_range(0, 2999) == 0) begin en = 0; hold[6] = $urandom_range(1, 5); end
            if (hold[7] > 0) begin hold[7]--; if (hold[7] == 0) rst_n = 1; end
            else if ($urandom_range(0, 7999) == 0) begin rst_n = 0; hold[7] = 2; end
            run(1);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not end, got 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule